// File: doc/BRIEF.md
# Register-Mapped EDID Read Controller

This block gives a host a small register window through which it reads a display identification table, in the way a display-bus controller would. The host picks a display port through a pin-select register, writes a command that names a target address, a start index, a byte count and a cycle type, polls a status register, and then pulls the table out of a data register four bytes per read. A 128-byte identification ROM is held inside the block. Two inputs, one bit per port, say whether a monitor is attached and whether that port carries a packet-based display link. Ports with such a link cannot give their table through this window.

A three-state bus phase machine (idle, data, wait) tracks each transfer. Every data-register read consumes up to four table bytes. The read that consumes the final byte moves the phase to idle or to wait, depending on the cycle type, and then closes the session. The status register carries a hardware-ready flag, a not-acknowledged flag, the two live phase flags and a sticky in-use flag.

Bus accesses take one cycle. Every read places its word on `bus_rdata` at the clock edge that accepts it.

Top module: `edid_i2c_regs`

## Requirements
- R1: After reset, the status, command, data and pin-select registers all read 0. Register addresses are: 0 pin select, 1 command, 2 status, 3 data.
- R2: The command register has these fields:
  - bit 0: read direction.
  - bits 7:1: target address.
  - bits 15:8: index.
  - bits 24:16: byte count.
  - bits 27:25: cycle type. Bit 26 is the index-enable bit.
  - bit 30: software-ready.
  - bit 31: clear-interrupt.
  
  A command write is stored and reads back unchanged, except that bit 30 always reads 0.
- R3: Only target address 0x50 selects the table. A read command to any other address is stored but returns only zero bytes, and the read pointer does not move.
- R4: Each data read returns n = min(4, count − pointer) bytes, with the first byte in bits 7:0. Byte lanes at n and above keep their previous value, and the pointer advances. A command with bit 26 set loads the pointer from the index field. Table byte k is 0x00 for k = 0 and k = 7, 0xFF for k = 1..6, and (13·k + 5) mod 256 for k ≥ 8.
- R5: A data read returns the last data value unchanged and has no side effect in any of these cases:
  - no bytes remain;
  - the stored command's read bit is 0.
  
  Host writes to the data register are ignored.
- R6: On the data read that reaches the count, the phase goes to idle for cycle types 5 and 7 and to wait for all others. The session is then cleared, so later data reads return the last value.
- R7: A command with cycle type 1, 3, 5 or 7 moves the phase to data. Status bit 2 (active) is 1 only in the data phase, and status bit 3 (wait) is 1 only in the wait phase.
- R8: A command with cycle type 4 (stop) acts only if the previously stored cycle type was nonzero. It then clears the session and moves the phase to idle.
- R9: A pin-select write with a value p from 1 to 4 maps to port p−1. It clears the session, sets hardware-ready (status bit 0) and moves the phase to wait. It clears not-acknowledged (status bit 1) if that port has a monitor and no packet link, and sets it otherwise. A value of 0, or of 5 to 7, only clears the session.
- R10: A status read returns the current value and then sets in-use (status bit 7). Writing 1 to bit 7 clears in-use. Status writes change no other bit.
- R11: A command write with bit 31 set, made while the stored bit 31 is 0, sets hardware-ready. A command write with bit 31 clear, made while the stored bit 31 is 1, stores nothing except clearing bit 31. It also sets the status to hardware-ready plus not-acknowledged if no table is available, and moves the phase to idle.
- R12: A table byte read past byte 127, without a selected target, or on a port with no available table returns 0, and the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered at the accepting edge |
| mon_present | input | NPORTS | Monitor attached, per port |
| port_is_dp | input | NPORTS | Port carries a packet-based display link |

## Verification
A wrong pointer or session flag shows at the data register on the very next read: bytes come out shifted, or as zeros where table bytes belong, or they keep arriving after the count should have closed the transfer. A wrong phase state shows at the next status read as a wrong active or wait bit. A badly packed lane shows as a stale or overwritten byte in the partial final word. The directed scenarios are built to make each of these visible within one or two accesses: partial final words, the table end, an index load, rejected ports and stop commands that are ignored.

// File: rtl/edid_pkg.sv
package edid_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_t;

    // register addresses
    localparam logic [1:0] RA_PIN  = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    // command bit positions
    localparam int CB_RD     = 0;
    localparam int CB_IDXEN  = 26;
    localparam int CB_SWRDY  = 30;
    localparam int CB_CLRINT = 31;

    // status bit positions
    localparam int SB_HWRDY = 0;
    localparam int SB_NAK   = 1;
    localparam int SB_ACT   = 2;
    localparam int SB_WAIT  = 3;
    localparam int SB_INUSE = 7;

    localparam logic [2:0] CY_NONE = 3'd0;
    localparam logic [2:0] CY_STOP = 3'd4;

    localparam logic [6:0] EDID_TARGET = 7'h50;

    // content of the identification ROM, computed
    function automatic logic [7:0] rom_byte(input logic [9:0] k);
        logic [31:0] t;
        t = 32'(k) * 32'd13 + 32'd5;
        if (k < 10'd8)
            return (k == 10'd0 || k == 10'd7) ? 8'h00 : 8'hFF;
        return t[7:0];
    endfunction

endpackage

// File: rtl/edid_rom.sv
module edid_rom
    import edid_pkg::*;
#(
    parameter int PTR_W = 9,
    parameter int LANES = 4
) (
    input  logic [PTR_W-1:0]      base,
    output logic [LANES-1:0][7:0] bytes
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PTR_W:0] at;
        logic [9:0]     at10;
        assign at   = {1'b0, base} + (PTR_W+1)'(g);
        assign at10 = 10'(at);
        assign bytes[g] = rom_byte(at10);
    end
endmodule

// File: rtl/edid_fetch.sv
module edid_fetch #(
    parameter int DEPTH = 128,
    parameter int PTR_W = 9,
    parameter int LANES = 4
) (
    input  logic [PTR_W-1:0]   ptr,
    input  logic [PTR_W-1:0]   count,
    input  logic               enable,
    input  logic [LANES*8-1:0] old_word,
    output logic [LANES*8-1:0] new_word,
    output logic [PTR_W-1:0]   next_ptr,
    output logic               has_left,
    output logic               last
);
    localparam logic [PTR_W:0] DEPTH_V = (PTR_W+1)'(DEPTH);
    localparam logic [PTR_W:0] LANES_V = (PTR_W+1)'(LANES);

    logic [LANES-1:0][7:0] rom_bytes;
    logic [LANES-1:0]      lane_in;
    logic [LANES-1:0]      lane_ok;

    edid_rom #(.PTR_W(PTR_W), .LANES(LANES)) i_rom (
        .base  (ptr),
        .bytes (rom_bytes)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        logic [PTR_W:0] at;
        assign at         = {1'b0, ptr} + (PTR_W+1)'(g);
        assign lane_in[g] = at < {1'b0, count};
        assign lane_ok[g] = enable && lane_in[g] && (at < DEPTH_V);
        assign new_word[g*8 +: 8] = !lane_in[g] ? old_word[g*8 +: 8] :
                                    lane_ok[g]  ? rom_bytes[g] : 8'h00;
    end

    always_comb begin
        next_ptr = ptr;
        for (int i = 0; i < LANES; i++)
            if (lane_ok[i])
                next_ptr = next_ptr + 1'b1;
    end

    assign has_left = {1'b0, count} > {1'b0, ptr};
    assign last     = {1'b0, count} <= ({1'b0, ptr} + LANES_V);
endmodule

// File: rtl/edid_phase_fsm.sv
module edid_phase_fsm
    import edid_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go_idle,
    input  logic   go_data,
    input  logic   go_wait,
    output phase_t phase,
    output logic   active,
    output logic   waiting
);
    phase_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (go_wait)      state_d = PH_WAIT;   // pin select
                else if (go_data) state_d = PH_DATA;   // start
            end
            PH_DATA: begin
                if (go_idle)      state_d = PH_IDLE;   // stop or final with stop
                else if (go_wait) state_d = PH_WAIT;   // final without stop, pin select
            end
            PH_WAIT: begin
                if (go_idle)      state_d = PH_IDLE;   // stop or controller reset
                else if (go_data) state_d = PH_DATA;   // restart
            end
            default:              state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        phase   = state_q;
        active  = (state_q == PH_DATA);
        waiting = (state_q == PH_WAIT);
    end
endmodule

// File: rtl/edid_i2c_regs.sv
module edid_i2c_regs
    import edid_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 128,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPORTS-1:0] mon_present,
    input  logic [NPORTS-1:0] port_is_dp
);
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int LANES  = 4;

    logic [2:0]       pinsel_q;
    logic [31:0]      cmd_q;
    logic [31:0]      data_q;
    logic [31:0]      rdata_q;
    logic             st_hwrdy, st_nak, st_inuse;
    logic             sess_on, sess_sel, sess_avail;
    logic [CNT_W-1:0] ptr_q, cnt_q;

    logic wr_pin, wr_cmd, wr_stat, rd_any;
    assign wr_pin  = bus_sel && bus_wr && (bus_addr == RA_PIN);
    assign wr_cmd  = bus_sel && bus_wr && (bus_addr == RA_CMD);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == RA_STAT);
    assign rd_any  = bus_sel && !bus_wr;

    // pin select decode
    logic [2:0]        pin_val;
    logic              pin_ok, pin_good;
    logic [PORT_W-1:0] port_idx;
    assign pin_val  = bus_wdata[2:0];
    assign pin_ok   = (pin_val != 3'd0) && ({1'b0, pin_val} <= 4'(NPORTS));
    assign port_idx = PORT_W'(pin_val - 3'd1);
    assign pin_good = mon_present[port_idx] && !port_is_dp[port_idx];

    // command decode
    logic [2:0]       w_cyc, q_cyc;
    logic [6:0]       w_tgt;
    logic [7:0]       w_idx;
    logic [CNT_W-1:0] w_cnt;
    logic             clr_held, stop_eff, data_cyc, ctl_reset;
    assign w_cyc     = bus_wdata[27:25];
    assign q_cyc     = cmd_q[27:25];
    assign w_tgt     = bus_wdata[7:1];
    assign w_idx     = bus_wdata[15:8];
    assign w_cnt     = bus_wdata[16 +: CNT_W];
    assign clr_held  = cmd_q[CB_CLRINT];
    assign ctl_reset = wr_cmd && clr_held && !bus_wdata[CB_CLRINT];
    assign stop_eff  = wr_cmd && !clr_held && (w_cyc == CY_STOP) && (q_cyc != CY_NONE);
    assign data_cyc  = (w_cyc == 3'd1) || (w_cyc == 3'd3) ||
                       (w_cyc == 3'd5) || (w_cyc == 3'd7);

    // data fetch
    logic [31:0]      fetch_word;
    logic [CNT_W-1:0] fetch_ptr;
    logic             has_left, last;
    logic             rd_data_live, final_rd, stop_type;

    edid_fetch #(.DEPTH(DEPTH), .PTR_W(CNT_W), .LANES(LANES)) i_fetch (
        .ptr      (ptr_q),
        .count    (cnt_q),
        .enable   (sess_on && sess_sel && sess_avail),
        .old_word (data_q),
        .new_word (fetch_word),
        .next_ptr (fetch_ptr),
        .has_left (has_left),
        .last     (last)
    );

    assign rd_data_live = rd_any && (bus_addr == RA_DATA) && cmd_q[CB_RD] && has_left;
    assign final_rd     = rd_data_live && last;
    assign stop_type    = (q_cyc == 3'd5) || (q_cyc == 3'd7);

    // phase machine
    phase_t phase;
    logic   ph_active, ph_waiting;
    logic   go_idle, go_data, go_wait;
    assign go_idle = ctl_reset || stop_eff || (final_rd && stop_type);
    assign go_data = wr_cmd && !clr_held && data_cyc;
    assign go_wait = (wr_pin && pin_ok) || (final_rd && !stop_type);

    edid_phase_fsm i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_idle (go_idle),
        .go_data (go_data),
        .go_wait (go_wait),
        .phase   (phase),
        .active  (ph_active),
        .waiting (ph_waiting)
    );

    logic [31:0] status_word;
    always_comb begin
        status_word           = '0;
        status_word[SB_HWRDY] = st_hwrdy;
        status_word[SB_NAK]   = st_nak;
        status_word[SB_ACT]   = ph_active;
        status_word[SB_WAIT]  = ph_waiting;
        status_word[SB_INUSE] = st_inuse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pinsel_q   <= '0;
            cmd_q      <= '0;
            data_q     <= '0;
            rdata_q    <= '0;
            st_hwrdy   <= 1'b0;
            st_nak     <= 1'b0;
            st_inuse   <= 1'b0;
            sess_on    <= 1'b0;
            sess_sel   <= 1'b0;
            sess_avail <= 1'b0;
            ptr_q      <= '0;
            cnt_q      <= '0;
        end else begin
            if (wr_pin) begin
                pinsel_q   <= pin_val;
                sess_on    <= pin_ok;
                sess_sel   <= 1'b0;
                sess_avail <= pin_ok && pin_good;
                ptr_q      <= '0;
                cnt_q      <= '0;
                if (pin_ok) begin
                    st_hwrdy <= 1'b1;
                    st_nak   <= !pin_good;
                end
            end
            if (wr_cmd) begin
                if (clr_held) begin
                    if (!bus_wdata[CB_CLRINT]) begin
                        cmd_q[CB_CLRINT] <= 1'b0;
                        st_hwrdy         <= 1'b1;
                        st_nak           <= !sess_avail;
                        st_inuse         <= 1'b0;
                    end
                end else begin
                    if (bus_wdata[CB_CLRINT])
                        st_hwrdy <= 1'b1;
                    cnt_q <= w_cnt;
                    if (w_tgt == EDID_TARGET)
                        sess_sel <= 1'b1;
                    if (bus_wdata[CB_IDXEN])
                        ptr_q <= CNT_W'(w_idx);
                    if (stop_eff) begin
                        sess_on    <= 1'b0;
                        sess_sel   <= 1'b0;
                        sess_avail <= 1'b0;
                        ptr_q      <= '0;
                        cnt_q      <= '0;
                    end
                    cmd_q           <= bus_wdata;
                    cmd_q[CB_SWRDY] <= 1'b0;
                end
            end
            if (wr_stat && bus_wdata[SB_INUSE])
                st_inuse <= 1'b0;
            if (rd_any) begin
                unique case (bus_addr)
                    RA_PIN:  rdata_q <= {29'b0, pinsel_q};
                    RA_CMD:  rdata_q <= cmd_q;
                    RA_STAT: begin
                        rdata_q  <= status_word;
                        st_inuse <= 1'b1;
                    end
                    RA_DATA: begin
                        if (rd_data_live) begin
                            rdata_q <= fetch_word;
                            data_q  <= fetch_word;
                            ptr_q   <= fetch_ptr;
                            if (last) begin
                                sess_on    <= 1'b0;
                                sess_sel   <= 1'b0;
                                sess_avail <= 1'b0;
                                ptr_q      <= '0;
                                cnt_q      <= '0;
                            end
                        end else begin
                            rdata_q <= data_q;
                        end
                    end
                    default: rdata_q <= rdata_q;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/edid_i2c_regs_chk.sv
module edid_i2c_regs_chk
    import edid_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        ph_active,
    input logic        ph_waiting,
    input logic        st_inuse,
    input logic [31:0] data_q,
    input logic [31:0] cmd_q
);
    // R7: any odd cycle type written without a held clear-interrupt enters the data phase
    a_r7_data_cycle_active: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RA_CMD && !cmd_q[CB_CLRINT] && bus_wdata[25])
        |=> (ph_active && !ph_waiting));

    // R10: a status read leaves in-use set
    a_r10_status_read_inuse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == RA_STAT) |=> st_inuse);

    // R5: host writes to the data register do not touch it
    a_r5_data_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RA_DATA) |=> $stable(data_q));

    // R5: data read under a non-read command returns the stored word
    a_r5_nonread_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == RA_DATA && !cmd_q[CB_RD])
        |=> (bus_rdata == $past(data_q) && $stable(data_q)));

    // R9: pin select 1 always maps to a port and enters the wait phase
    a_r9_pin_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RA_PIN && bus_wdata[2:0] == 3'd1)
        |=> (ph_waiting && !ph_active));

    // R8: an effective stop leaves both phase flags low
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RA_CMD && !cmd_q[CB_CLRINT] &&
         bus_wdata[27:25] == CY_STOP && cmd_q[27:25] != CY_NONE)
        |=> (!ph_active && !ph_waiting));

    // R2: stored software-ready bit never reads back as 1
    a_r2_swrdy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == RA_CMD) |=> !bus_rdata[CB_SWRDY]);
endmodule

bind edid_i2c_regs edid_i2c_regs_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ph_active  (ph_active),
    .ph_waiting (ph_waiting),
    .st_inuse   (st_inuse),
    .data_q     (data_q),
    .cmd_q      (cmd_q)
);

// File: tb/test_edid_i2c_regs.sv
`timescale 1ns/1ps
module test_edid_i2c_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  mon_present = 4'b0111;
    logic [3:0]  port_is_dp  = 4'b0010;

    int n_checks = 0;
    int n_fail   = 0;
    bit inuse_exp = 1'b0;

    localparam logic [31:0] S_HW = 32'h01, S_NAK = 32'h02, S_ACT = 32'h04,
                            S_WT = 32'h08, S_IU = 32'h80;

    always #10 clk = ~clk;

    edid_i2c_regs i_edid_i2c_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mon_present(mon_present), .port_is_dp(port_is_dp)
    );

    function automatic logic [7:0] tbl(input int k);
        if (k == 0 || k == 7) return 8'h00;
        if (k < 8) return 8'hFF;
        return 8'((k * 13 + 5) % 256);
    endfunction

    function automatic logic [31:0] word4(input int k);
        return {tbl(k+3), tbl(k+2), tbl(k+1), tbl(k)};
    endfunction

    function automatic logic [31:0] mk_cmd(input bit rd, input int tgt, input int idx,
                                           input int cnt, input int cyc);
        return (32'(cyc) << 25) | (32'(cnt) << 16) | (32'(idx) << 8) |
               (32'(tgt) << 1) | 32'(rd);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk_status(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(2'd2, v);
        check(req, v, exp | (inuse_exp ? S_IU : 32'h0));
        inuse_exp = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk_status("R1 status", 32'h0);
        rd(2'd1, v); check("R1 command", v, 32'h0);
        rd(2'd3, v); check("R1 data", v, 32'h0);
        rd(2'd0, v); check("R1 pin", v, 32'h0);
    endtask

    task automatic t_inuse();
        chk_status("R10 in-use set", 32'h0);
        wr(2'd2, 32'hFFFF_FF7F);
        chk_status("R10 other bits read-only", 32'h0);
        wr(2'd2, 32'h0000_0080);
        inuse_exp = 1'b0;
        chk_status("R10 in-use cleared", 32'h0);
    endtask

    task automatic t_clrint();
        logic [31:0] v;
        wr(2'd1, 32'h8000_0000);
        chk_status("R11 clear-int sets ready", S_HW);
        wr(2'd1, 32'h0012_3456);
        rd(2'd1, v); check("R11 only clear bit dropped", v, 32'h0);
        inuse_exp = 1'b0;
        chk_status("R11 controller reset", S_HW | S_NAK);
    endtask

    task automatic t_read_stop();
        logic [31:0] v, c;
        wr(2'd0, 32'd1);
        chk_status("R9 pin ok non-DP", S_HW | S_WT);
        rd(2'd0, v); check("R9 pin readback", v, 32'd1);
        c = mk_cmd(1, 'h50, 0, 10, 7);
        wr(2'd1, c | 32'h4000_0000);
        rd(2'd1, v); check("R2 sw-ready forced low", v, c);
        chk_status("R7 active", S_HW | S_ACT);
        rd(2'd3, v); check("R4 bytes 0-3", v, word4(0));
        rd(2'd3, v); check("R4 bytes 4-7", v, word4(4));
        rd(2'd3, v); check("R4 partial lanes", v, {tbl(7), tbl(6), tbl(9), tbl(8)});
        chk_status("R6 stop type to idle", S_HW);
        rd(2'd3, v); check("R5 R6 no bytes left", v, {tbl(7), tbl(6), tbl(9), tbl(8)});
    endtask

    task automatic t_index_wait();
        logic [31:0] v;
        wr(2'd0, 32'd3);
        wr(2'd1, mk_cmd(1, 'h50, 16, 20, 3));
        rd(2'd3, v); check("R4 index load", v, word4(16));
        chk_status("R6 wait type to wait", S_HW | S_WT);
    endtask

    task automatic t_boundary();
        logic [31:0] v;
        wr(2'd0, 32'd1);
        wr(2'd1, mk_cmd(1, 'h50, 126, 132, 7));
        rd(2'd3, v); check("R12 past table end", v, {8'h00, 8'h00, tbl(127), tbl(126)});
        rd(2'd3, v); check("R12 all past end", v, 32'h0);
        chk_status("R12 final idle", S_HW);
    endtask

    task automatic t_nak();
        logic [31:0] v;
        wr(2'd0, 32'd2);
        chk_status("R9 DP port nak", S_HW | S_NAK | S_WT);
        wr(2'd1, mk_cmd(1, 'h50, 0, 4, 5));
        rd(2'd3, v); check("R12 no table available", v, 32'h0);
        wr(2'd0, 32'd4);
        chk_status("R9 absent monitor nak", S_HW | S_NAK | S_WT);
        wr(2'd0, 32'd0);
        chk_status("R9 pin zero no status change", S_HW | S_NAK | S_WT);
        rd(2'd0, v); check("R9 pin zero readback", v, 32'd0);
        wr(2'd0, 32'd6);
        chk_status("R9 pin out of range", S_HW | S_NAK | S_WT);
    endtask

    task automatic t_addr();
        logic [31:0] v;
        wr(2'd0, 32'd1);
        wr(2'd1, mk_cmd(1, 'h51, 0, 8, 1));
        rd(2'd3, v); check("R3 other target zero", v, 32'h0);
        chk_status("R3 pointer held, still active", S_HW | S_ACT);
        wr(2'd1, mk_cmd(0, 0, 0, 0, 4));
        chk_status("R8 effective stop", S_HW);
    endtask

    task automatic t_stop_ignored();
        wr(2'd0, 32'd1);
        wr(2'd1, mk_cmd(0, 0, 0, 0, 0));
        wr(2'd1, mk_cmd(0, 0, 0, 0, 4));
        chk_status("R8 stop after no-cycle ignored", S_HW | S_WT);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(2'd0, 32'd1);
        wr(2'd1, mk_cmd(1, 'h50, 0, 8, 1));
        rd(2'd3, v); check("R4 first word", v, word4(0));
        wr(2'd3, 32'hDEAD_BEEF);
        wr(2'd1, mk_cmd(0, 'h50, 0, 8, 1));
        rd(2'd3, v); check("R5 non-read returns last", v, word4(0));
        wr(2'd1, mk_cmd(1, 'h50, 0, 8, 1));
        rd(2'd3, v); check("R5 pointer untouched", v, word4(4));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inuse();
        t_clrint();
        t_read_stop();
        t_index_wait();
        t_boundary();
        t_nak();
        t_addr();
        t_stop_ignored();
        t_ignore();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule